// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Controller

This block is a clocked model of the write side of an 8K x 8 byte-wide nonvolatile memory. Three active-low strobes (chip enable, output enable, write enable) are sampled on the system clock. A write interval is the span during which chip enable and write enable are both low and output enable is high. Each accepted interval loads one byte into a 32-entry staging page and marks that entry as loaded.

Each completed write restarts an inactivity timer. If the next write interval begins before the timer runs out, the page load simply continues, and a page load has no limit on its total length. When the timer expires, the block raises `busy` and runs an internal program cycle. During that cycle it walks the 32 page slots in ascending order and issues one array write strobe for each loaded slot only. It then waits out a settle period before it clears the loaded mask and drops `busy`.

Write intervals that are too short are treated as noise and discarded. Writes are also ignored during a power-up hold-off after reset and during the program cycle. All durations are parameters counted in clock cycles.

Top module: `page_write_ctrl`

## Requirements
- R1: A byte is loaded only from an interval with chip enable low, write enable low and output enable high at the same time. Output enable low or chip enable high blocks loading, and no program cycle follows.
- R2: The byte address is taken when the write interval opens, which is the later of the two strobes' falling edges. The data byte is taken when the interval closes, which is the earlier of the two rising edges.
- R3: Address bits [4:0] pick one of 32 page slots, and slots may be loaded in any order. A later load of the same slot replaces its data. Every array write in a cycle uses address bits [12:5] from the last accepted write as the page.
- R4: The window timer restarts after each accepted write ends. A write that qualifies before expiry cancels the pending timeout. With no further write, `busy` rises on the (WINDOW_CYC+2)-th clock edge after write enable is sampled high.
- R5: A program cycle keeps `busy` high for 32 + PROG_CYC cycles. It issues exactly one `arr_we` pulse for each loaded slot, in ascending slot order, carrying that slot's data, and `arr_we` is never high without `busy`.
- R6: A write interval lasting fewer than GLITCH_CYC sampled cycles loads nothing and does not stop the window timer. An interval lasting exactly GLITCH_CYC cycles is accepted.
- R7: For INHIBIT_CYC cycles after reset, write intervals are ignored, and no program cycle results from them.
- R8: Write intervals during `busy` are ignored. The loaded mask is cleared when the cycle ends, so the next cycle writes only the slots loaded after it.
- R9: During and right after reset, `busy` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low blocks writes |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address; [12:5] page, [4:0] slot |
| din | input | 8 | Write data |
| busy | output | 1 | High during the internal program cycle |
| arr_we | output | 1 | Array write strobe, one cycle per loaded slot |
| arr_addr | output | 13 | Array address for the current strobe |
| arr_data | output | 8 | Array data for the current strobe |

## Verification
The embedded assertions watch properties that must hold on every cycle. The array strobe never fires outside `busy`, and the window timer never runs during a program cycle. Every program cycle starts from a running timer. The loaded mask stays empty through the power-up hold-off, stays frozen while `busy` is high, and is empty when `busy` falls. Other behaviour can only be shown by scenarios in the bench: which address and data edges are captured, the page taken from the last write, the exact expiry cycle and its extension, glitch rejection at the threshold, and the selective, ordered set of array writes.

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BITS   = 5,
  parameter int GLITCH_CYC  = 2,
  parameter int WINDOW_CYC  = 5000,
  parameter int PROG_CYC    = 250000,
  parameter int INHIBIT_CYC = 375000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);

  localparam int PAGE_SZ = 1 << PAGE_BITS;
  localparam int PG_W    = ADDR_W - PAGE_BITS;
  localparam int LEN_W   = $clog2(GLITCH_CYC + 1);
  localparam int TMR_W   = $clog2(WINDOW_CYC + 1);
  localparam int SET_W   = $clog2(PROG_CYC + 1);
  localparam int INH_W   = $clog2(INHIBIT_CYC + 1);

  logic              ce_s, oe_s, we_s;
  logic [ADDR_W-1:0] a_s, lat_addr;
  logic [DATA_W-1:0] d_s;
  logic [DATA_W-1:0] pbuf [PAGE_SZ];
  logic [PAGE_SZ-1:0] mask;
  logic [PG_W-1:0]   page;
  logic [INH_W-1:0]  inh_cnt;
  logic              inh;
  logic              wr_q;
  logic [LEN_W-1:0]  len, cur_len;
  logic              tmr_run;
  logic [TMR_W-1:0]  tmr;
  logic              scan, settle;
  logic [PAGE_BITS-1:0] idx;
  logic [SET_W-1:0]  sc;

  wire accept  = !inh && !busy;
  wire wr_act  = !ce_s && !we_s && oe_s && accept;
  wire qual_now = wr_act && (cur_len >= LEN_W'(GLITCH_CYC));
  wire p_end   = !wr_act && wr_q && (len >= LEN_W'(GLITCH_CYC));
  wire [PAGE_BITS-1:0] slot = lat_addr[PAGE_BITS-1:0];

  always_comb begin
    if (!wr_q)                           cur_len = LEN_W'(1);
    else if (len >= LEN_W'(GLITCH_CYC))  cur_len = len;
    else                                 cur_len = len + LEN_W'(1);
  end

  assign busy     = scan | settle;
  assign arr_we   = scan & mask[idx];
  assign arr_addr = {page, idx};
  assign arr_data = pbuf[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_s <= 1'b1;
      oe_s <= 1'b1;
      we_s <= 1'b1;
      a_s  <= '0;
      d_s  <= '0;
    end else begin
      ce_s <= ce_n;
      oe_s <= oe_n;
      we_s <= we_n;
      a_s  <= addr;
      d_s  <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh     <= (INHIBIT_CYC != 0);
      inh_cnt <= '0;
    end else if (inh) begin
      if (inh_cnt == INH_W'(INHIBIT_CYC - 1)) inh <= 1'b0;
      else                                   inh_cnt <= inh_cnt + INH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (p_end) pbuf[slot] <= d_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      len      <= '0;
      lat_addr <= '0;
      mask     <= '0;
      page     <= '0;
      tmr_run  <= 1'b0;
      tmr      <= '0;
      scan     <= 1'b0;
      settle   <= 1'b0;
      idx      <= '0;
      sc       <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act) len <= cur_len;
      if (wr_act && !wr_q) lat_addr <= a_s;

      if (p_end) begin
        mask[slot] <= 1'b1;
        page       <= lat_addr[ADDR_W-1:PAGE_BITS];
        tmr_run    <= 1'b1;
        tmr        <= '0;
      end else if (qual_now) begin
        tmr_run <= 1'b0;
      end else if (tmr_run) begin
        if (tmr == TMR_W'(WINDOW_CYC - 1)) begin
          tmr_run <= 1'b0;
          scan    <= 1'b1;
          idx     <= '0;
        end else begin
          tmr <= tmr + TMR_W'(1);
        end
      end

      if (scan) begin
        if (idx == PAGE_BITS'(PAGE_SZ - 1)) begin
          scan   <= 1'b0;
          settle <= 1'b1;
          sc     <= '0;
        end else begin
          idx <= idx + PAGE_BITS'(1);
        end
      end

      if (settle) begin
        if (sc == SET_W'(PROG_CYC - 1)) begin
          settle <= 1'b0;
          mask   <= '0;
        end else begin
          sc <= sc + SET_W'(1);
        end
      end
    end
  end

  // R5
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R4
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run |-> !busy);

  // R4
  start_from_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tmr_run));

  // R7
  holdoff_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inh |-> (mask == '0));

  // R8
  mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask));

  // R8
  mask_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mask == '0));

endmodule

// File: tb/tb_page_write_ctrl.sv
module tb_page_write_ctrl;
  localparam int G   = 3;
  localparam int W   = 12;
  localparam int P   = 16;
  localparam int INH = 20;
  localparam int NV  = 7;

  // {3'b0, addr[12:0], data[7:0], low_cycles[3:0], 3'b0, final_keep}
  localparam logic [31:0] VEC [NV] = '{
    {3'b0, 13'h0245, 8'hA1, 4'd4, 3'b0, 1'b0},
    {3'b0, 13'h0240, 8'h3C, 4'd4, 3'b0, 1'b1},
    {3'b0, 13'h025F, 8'h7E, 4'd4, 3'b0, 1'b1},
    {3'b0, 13'h0247, 8'h99, 4'd2, 3'b0, 1'b0},
    {3'b0, 13'h0243, 8'h0F, 4'd3, 3'b0, 1'b1},
    {3'b0, 13'h0245, 8'h5A, 4'd4, 3'b0, 1'b1},
    {3'b0, 13'h00A1, 8'hC3, 4'd4, 3'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic busy, arr_we;
  logic [12:0] arr_addr;
  logic [7:0]  arr_data;

  int checks = 0, fails = 0;
  int lg_n = 0, n_starts = 0, busy_len = 0;
  bit busy_q = 1'b0, done = 1'b0;
  logic [12:0] lg_a [64];
  logic [7:0]  lg_d [64];

  always #10 clk = ~clk;

  page_write_ctrl #(.GLITCH_CYC(G), .WINDOW_CYC(W), .PROG_CYC(P), .INHIBIT_CYC(INH)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data));

  always @(negedge clk) begin
    if (arr_we && lg_n < 64) begin
      lg_a[lg_n] = arr_addr;
      lg_d[lg_n] = arr_data;
      lg_n++;
    end
    if (busy && !busy_q) begin
      n_starts++;
      busy_len = 0;
    end
    if (busy) busy_len++;
    busy_q = busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [12:0] a);
    for (int i = 0; i < lg_n; i++) if (lg_a[i] == a) return i;
    return -1;
  endfunction

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input int low,
                    input logic ce_lvl, input logic oe_lvl);
    @(negedge clk);
    addr = a; din = d; ce_n = ce_lvl; oe_n = oe_lvl; we_n = 1'b0;
    repeat (low) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; din = ~d;
  endtask

  task automatic wait_prog(output bit ok);
    int n;
    n = 0;
    while (!busy && n < 500) begin @(negedge clk); n++; end
    while (busy && n < 1000) begin @(negedge clk); n++; end
    ok = (n < 1000) && !busy;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    int s0, k, prev;
    logic [7:0] lastpg;

    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 busy in reset", busy, 0);
    chk(arr_we == 1'b0, "R9 arr_we in reset", arr_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && arr_we == 1'b0, "R9 after reset", {busy, arr_we}, 0);

    // R7: write during hold-off is ignored
    wr(13'h0100, 8'h11, 4, 1'b0, 1'b1);
    repeat (INH + W + 10) @(negedge clk);
    chk(n_starts == 0, "R7 holdoff write", n_starts, 0);

    // R1: output enable low, then chip enable high
    wr(13'h0101, 8'h22, 4, 1'b0, 1'b0);
    repeat (W + 10) @(negedge clk);
    chk(n_starts == 0, "R1 oe low blocks", n_starts, 0);
    wr(13'h0102, 8'h33, 4, 1'b1, 1'b1);
    repeat (W + 10) @(negedge clk);
    chk(n_starts == 0, "R1 ce high blocks", n_starts, 0);

    // R3 / R6 / R5: table of page loads
    lg_n = 0;
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][28:16], VEC[i][15:8], int'(VEC[i][7:4]), 1'b0, 1'b1);
      @(negedge clk);
    end
    wait_prog(ok);
    chk(ok, "R5 program completes", ok, 1);
    chk(busy_len == 32 + P, "R5 busy length", busy_len, 32 + P);
    chk(lg_n == 5, "R5 strobe count", lg_n, 5);
    lastpg = VEC[NV-1][28:21];
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][0]) begin
        k = find({lastpg, VEC[i][20:16]});
        chk(k >= 0 && lg_d[k] == VEC[i][15:8], "R3 slot data on last page",
            (k >= 0) ? int'(lg_d[k]) : -1, VEC[i][15:8]);
      end
    end
    k = find({lastpg, 5'h07});
    chk(k < 0, "R6 short pulse dropped", k, -1);
    prev = -1;
    ok = 1'b1;
    for (int i = 0; i < lg_n; i++) begin
      if (int'(lg_a[i]) <= prev) ok = 1'b0;
      prev = lg_a[i];
    end
    chk(ok, "R5 ascending order", ok, 1);

    // R4: exact expiry cycle
    lg_n = 0;
    s0 = n_starts;
    wr(13'h0302, 8'h44, 4, 1'b0, 1'b1);
    repeat (W) @(negedge clk);
    chk(busy == 1'b0, "R4 before expiry", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R4 at expiry", busy, 1);
    wait_prog(ok);

    // R4: second write cancels pending timeout
    lg_n = 0;
    s0 = n_starts;
    wr(13'h0303, 8'h55, 4, 1'b0, 1'b1);
    repeat (W - 6) @(negedge clk);
    wr(13'h0304, 8'h66, 4, 1'b0, 1'b1);
    repeat (W) @(negedge clk);
    chk(n_starts == s0 && busy == 1'b0, "R4 window extended", n_starts - s0, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R4 extended expiry", busy, 1);
    wait_prog(ok);
    chk(lg_n == 2 && n_starts == s0 + 1, "R4 one cycle two bytes", lg_n, 2);

    // R8: writes during busy ignored, mask cleared
    lg_n = 0;
    wr(13'h0310, 8'h10, 4, 1'b0, 1'b1);
    while (!busy) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(13'h0312, 8'h77, 4, 1'b0, 1'b1);
    wait_prog(ok);
    s0 = n_starts;
    repeat (W + 10) @(negedge clk);
    chk(n_starts == s0, "R8 busy write ignored", n_starts - s0, 0);
    lg_n = 0;
    wr(13'h0305, 8'h12, 4, 1'b0, 1'b1);
    wait_prog(ok);
    chk(lg_n == 1 && lg_a[0] == 13'h0305, "R8 mask cleared", lg_n, 1);

    // R2: chip-enable controlled interval with moving address and data
    lg_n = 0;
    @(negedge clk);
    addr = 13'h0408; din = 8'h00; we_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); addr = 13'h0415;
    @(negedge clk); din = 8'hD4;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); din = 8'h00; we_n = 1'b1;
    wait_prog(ok);
    k = find(13'h0408);
    chk(k >= 0 && lg_d[k] == 8'hD4, "R2 addr at open data at close",
        (k >= 0) ? int'(lg_d[k]) : -1, 8'hD4);
    chk(find(13'h0415) < 0 && lg_n == 1, "R2 late address unused", lg_n, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule